// File: doc/BRIEF.md
# Double-Buffered Clock Register Front End

This block is the byte-wide bus front end of a battery-backed calendar clock. It claims the eight highest addresses of an asynchronous SRAM-style address space for clock registers. Every other address is reported on a select output, so that a neighbouring RAM array can serve it. The bus enables are sampled on a system clock. A read returns data one cycle after the read condition is sampled. A write takes effect once the write condition ends, that is when write enable or chip enable rises, whichever comes first.

The running calendar counters sit outside the block. They present their BCD fields on a packed input bus. The block keeps a separate user copy of those fields, and that copy is what software reads. Two control bits in the century register decide whether the copy follows the counters. The freeze bit holds the copy still while the counters keep running. The hold bit also stops the copy, and lets software write new time values into it. Clearing the hold bit sends the copy to the counters as a one-cycle parallel load. After either bit is released, the copy is refreshed from the counters on the next one-second tick or after a fixed number of cycles, whichever comes first. The block also holds an oscillator-stop bit and a frequency-test bit, and it reports a read-only battery-status bit.

Top module: `rtcf_regfile`

## Requirements
- R1: An address whose upper bits (all bits above bit 2) are all ones selects a clock register. Its low three bits pick the register: 7 year, 6 month, 5 date, 4 day, 3 hour, 2 minutes, 1 seconds, 0 century/control. Any other address with chip enable low raises `ram_sel` instead, and the block never drives data for it.
- R2: A read is a sampled cycle with chip enable low, output enable low and write enable high. `dout_en` and `dout` show it one clock after the sample. A write is committed once the sampled chip-enable-low and write-enable-low condition ends, whichever enable rises first. While write enable is low, `dout_en` stays 0.
- R3: When neither control bit is set and no refresh is pending, a read of a time register returns the counter field, masked to its valid bits.
- R4: Writing the century register with bit 6 set freezes the seven time registers. Later counter changes do not show, and the century register reads back with bit 6 set.
- R5: After the freeze and hold bits are both cleared, the user copy keeps its frozen values. It reloads from the counters on the first `tick_1s` or after REFRESH_DLY cycles, whichever comes first.
- R6: Writing the century register with bit 7 set starts a hold. While the hold lasts, the copy ignores the counters, and writes to time registers are stored and read back.
- R7: When a century write clears bit 7, `load_en` pulses for exactly one cycle. `load_bus` then carries the user copy, with register n at bits 8n+7..8n.
- R8: Writes to the time fields are ignored while the hold bit is 0. The century field is written only by a century write with bit 7 set.
- R9: Unused bits are discarded on write and read as 0. The value masks are: century 0x3F, seconds 0x7F, minutes 0x7F, hour 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R10: Seconds bit 7 is the oscillator-stop bit. It can be written at any time and it reads back. `osc_run` is its inverse.
- R11: Day bit 6 is the frequency-test bit. It can be written at any time. While it is set and the oscillator runs, seconds bit 0 reads a phase that toggles on every `tick_512` strobe. The phase is 0 otherwise.
- R12: Day bit 7 always reads `batt_ok`. Writes to it have no effect.
- R13: After reset the block is in this state: the hold, freeze, oscillator-stop and frequency-test bits are all 0, `dout_en` is 0 and `load_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driving |
| dout_en | output | 1 | Read data valid / drive enable |
| cs_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| ram_sel | output | 1 | Access falls below the clock registers |
| cnt_bus | input | 64 | Counter fields, register n at bits 8n+7..8n |
| tick_1s | input | 1 | One-cycle strobe on each counter second |
| tick_512 | input | 1 | One-cycle strobe at the test frequency |
| batt_ok | input | 1 | Battery status, 1 = good |
| osc_run | output | 1 | Counter enable (inverse of oscillator-stop) |
| load_en | output | 1 | One-cycle parallel load strobe to the counters |
| load_bus | output | 64 | Values to load, same layout as cnt_bus |

## Verification
Wrong freeze or hold state shows on the next read of any time register. The block then returns a live counter value where a held value is expected, or the reverse. A pending refresh that never resolves leaves stale values visible after a tick or after REFRESH_DLY cycles. A refresh that resolves too early shows new values on a read made right after the release. A wrong write commit point or a wrong mask shows on the read-back one access later. A missing or repeated load pulse shows in the count of captured `load_en` cycles within a cycle or two of the releasing write.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;

  localparam int NREG = 8;
  localparam int BUSW = NREG * 8;

  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_SEC   = 3'd1,
    IDX_MIN   = 3'd2,
    IDX_HOUR  = 3'd3,
    IDX_DAY   = 3'd4,
    IDX_DATE  = 3'd5,
    IDX_MONTH = 3'd6,
    IDX_YEAR  = 3'd7
  } reg_idx_e;

  // valid value bits of each register field
  function automatic logic [7:0] field_mask(input logic [2:0] idx);
    logic [7:0] m;
    case (idx)
      IDX_CTRL:  m = 8'h3F;
      IDX_SEC:   m = 8'h7F;
      IDX_MIN:   m = 8'h7F;
      IDX_HOUR:  m = 8'h3F;
      IDX_DAY:   m = 8'h07;
      IDX_DATE:  m = 8'h3F;
      IDX_MONTH: m = 8'h1F;
      default:   m = 8'hFF;
    endcase
    return m;
  endfunction

  // merge control and status bits into a stored field for a read
  function automatic logic [7:0] compose_byte(
    input logic [2:0] idx,
    input logic [7:0] field,
    input logic       hold,
    input logic       frz,
    input logic       osc_stop,
    input logic       ftest,
    input logic       phase,
    input logic       batt
  );
    logic [7:0] b;
    b = field;
    case (idx)
      IDX_CTRL: begin
        b[7] = hold;
        b[6] = frz;
      end
      IDX_SEC: begin
        b[7] = osc_stop;
        if (ftest && !osc_stop) b[0] = phase;
      end
      IDX_DAY: begin
        b[7] = batt;
        b[6] = ftest;
      end
      default: ;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rtcf_bus_decode.sv
module rtcf_bus_decode #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  output logic          rd_act,
  output logic [2:0]    rd_idx,
  output logic          wr_commit,
  output logic [2:0]    wr_idx,
  output logic [7:0]    wr_data,
  output logic          ram_sel
);
  localparam int HIW = AW - 3;

  logic          s_cs_n, s_oe_n, s_we_n;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_din;
  logic          s_top;
  logic          wr_now;
  logic          wr_q;
  logic          w_top;
  logic [2:0]    w_idx;
  logic [7:0]    w_data;

  // sample the asynchronous bus once per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_cs_n <= cs_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  assign s_top  = &s_addr[AW-1:3];
  assign wr_now = !s_cs_n && !s_we_n;

  // hold the last address/data seen during the write condition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      w_top  <= 1'b0;
      w_idx  <= '0;
      w_data <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now) begin
        w_top  <= s_top;
        w_idx  <= s_addr[2:0];
        w_data <= s_din;
      end
    end
  end

  assign wr_commit = wr_q && !wr_now && w_top;
  assign wr_idx    = w_idx;
  assign wr_data   = w_data;
  assign rd_act    = !s_cs_n && !s_oe_n && s_we_n && s_top;
  assign rd_idx    = s_addr[2:0];
  assign ram_sel   = !s_cs_n && !s_top;

  initial begin
    if (HIW < 1) $error("rtcf_bus_decode: AW must exceed 3");
  end

  assert_commit_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(!cs_n && !we_n, 2));

endmodule

// File: rtl/rtcf_shadow.sv
module rtcf_shadow
  import rtcf_pkg::*;
#(
  parameter int REFRESH_DLY = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_commit,
  input  logic [2:0]      wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [BUSW-1:0] cnt_bus,
  input  logic            tick_1s,
  input  logic            tick_512,
  output logic [BUSW-1:0] ucopy,
  output logic            hold_q,
  output logic            frz_q,
  output logic            osc_stop_q,
  output logic            ftest_q,
  output logic            ft_phase,
  output logic            load_en,
  output logic [BUSW-1:0] load_bus
);
  localparam int DW = $clog2(REFRESH_DLY + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(REFRESH_DLY - 1);

  logic [BUSW-1:0] cnt_m;
  logic            wr_ctrl, wr_sec, wr_day, wr_time;
  logic            hold_nxt, frz_nxt;
  logic            frozen, release_ev, hold_rel;
  logic            pend;
  logic [DW-1:0]   dly;
  logic            refresh_now, follow;

  // per-field masking of the counter bus
  for (genvar g = 0; g < NREG; g++) begin : g_mask
    assign cnt_m[g*8 +: 8] = cnt_bus[g*8 +: 8] & field_mask(3'(g));
  end

  assign wr_ctrl = wr_commit && (wr_idx == IDX_CTRL);
  assign wr_sec  = wr_commit && (wr_idx == IDX_SEC);
  assign wr_day  = wr_commit && (wr_idx == IDX_DAY);
  assign wr_time = wr_commit && (wr_idx != IDX_CTRL) && hold_q;

  assign hold_nxt   = wr_ctrl ? wr_data[7] : hold_q;
  assign frz_nxt    = wr_ctrl ? wr_data[6] : frz_q;
  assign frozen     = hold_q || frz_q;
  assign release_ev = frozen && !(hold_nxt || frz_nxt);
  assign hold_rel   = hold_q && !hold_nxt;

  assign refresh_now = pend && !frozen && !load_en && (tick_1s || (dly == DLY_LAST));
  assign follow      = !frozen && !pend;

  // control bits and the parallel load strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      frz_q      <= 1'b0;
      osc_stop_q <= 1'b0;
      ftest_q    <= 1'b0;
      load_en    <= 1'b0;
      load_bus   <= '0;
    end else begin
      hold_q  <= hold_nxt;
      frz_q   <= frz_nxt;
      load_en <= hold_rel;
      if (hold_rel) load_bus <= ucopy;
      if (wr_sec) osc_stop_q <= wr_data[7];
      if (wr_day) ftest_q    <= wr_data[6];
    end
  end

  // pending refresh after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dly  <= '0;
    end else if (release_ev) begin
      pend <= 1'b1;
      dly  <= '0;
    end else if (refresh_now) begin
      pend <= 1'b0;
    end else if (pend && (dly != DLY_LAST)) begin
      dly <= dly + 1'b1;
    end
  end

  // user-visible copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucopy <= '0;
    end else begin
      if (follow || refresh_now) ucopy <= cnt_m;
      if (wr_time)
        ucopy[{wr_idx, 3'b000} +: 8] <= wr_data & field_mask(wr_idx);
      else if (wr_ctrl && wr_data[7])
        ucopy[7:0] <= wr_data & field_mask(IDX_CTRL);
    end
  end

  // frequency-test phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ft_phase <= 1'b0;
    else if (!ftest_q || osc_stop_q) ft_phase <= 1'b0;
    else if (tick_512)               ft_phase <= !ft_phase;
  end

  assert_freeze_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !hold_q) |=> $stable(ucopy[BUSW-1:8]));

  assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en);

  assert_refresh_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !frozen && !load_en && (dly == DLY_LAST)) |=> !pend);

  assert_phase_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ft_phase |-> $past(ftest_q && !osc_stop_q));

endmodule

// File: rtl/rtcf_read_mux.sv
module rtcf_read_mux
  import rtcf_pkg::*;
(
  input  logic            rd_act,
  input  logic [2:0]      rd_idx,
  input  logic [BUSW-1:0] ucopy,
  input  logic            hold_q,
  input  logic            frz_q,
  input  logic            osc_stop_q,
  input  logic            ftest_q,
  input  logic            ft_phase,
  input  logic            batt_ok,
  output logic [7:0]      dout,
  output logic            dout_en
);
  logic [7:0] sel_field;
  logic [7:0] merged;

  always_comb begin
    sel_field = ucopy[{rd_idx, 3'b000} +: 8];
    merged    = compose_byte(rd_idx, sel_field, hold_q, frz_q, osc_stop_q,
                             ftest_q, ft_phase, batt_ok);
    dout      = rd_act ? merged : 8'h00;
    dout_en   = rd_act;
  end

endmodule

// File: rtl/rtcf_regfile.sv
module rtcf_regfile
  import rtcf_pkg::*;
#(
  parameter int AW          = 19,
  parameter int REFRESH_DLY = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            dout_en,
  input  logic            cs_n,
  input  logic            oe_n,
  input  logic            we_n,
  output logic            ram_sel,
  input  logic [BUSW-1:0] cnt_bus,
  input  logic            tick_1s,
  input  logic            tick_512,
  input  logic            batt_ok,
  output logic            osc_run,
  output logic            load_en,
  output logic [BUSW-1:0] load_bus
);
  logic            rd_act;
  logic [2:0]      rd_idx;
  logic            wr_commit;
  logic [2:0]      wr_idx;
  logic [7:0]      wr_data;
  logic [BUSW-1:0] ucopy;
  logic            hold_q, frz_q, osc_stop_q, ftest_q, ft_phase;

  rtcf_bus_decode #(.AW(AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .din       (din),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .rd_act    (rd_act),
    .rd_idx    (rd_idx),
    .wr_commit (wr_commit),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ram_sel   (ram_sel)
  );

  rtcf_shadow #(.REFRESH_DLY(REFRESH_DLY)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_commit  (wr_commit),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cnt_bus    (cnt_bus),
    .tick_1s    (tick_1s),
    .tick_512   (tick_512),
    .ucopy      (ucopy),
    .hold_q     (hold_q),
    .frz_q      (frz_q),
    .osc_stop_q (osc_stop_q),
    .ftest_q    (ftest_q),
    .ft_phase   (ft_phase),
    .load_en    (load_en),
    .load_bus   (load_bus)
  );

  rtcf_read_mux u_rmux (
    .rd_act     (rd_act),
    .rd_idx     (rd_idx),
    .ucopy      (ucopy),
    .hold_q     (hold_q),
    .frz_q      (frz_q),
    .osc_stop_q (osc_stop_q),
    .ftest_q    (ftest_q),
    .ft_phase   (ft_phase),
    .batt_ok    (batt_ok),
    .dout       (dout),
    .dout_en    (dout_en)
  );

  assign osc_run = !osc_stop_q;

  initial begin
    if (REFRESH_DLY < 2) $error("rtcf_regfile: REFRESH_DLY must be at least 2");
  end

  assert_read_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!cs_n && !oe_n && we_n));

  assert_decode_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && dout_en));

  assert_osc_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && (wr_idx == IDX_SEC)) |=> (osc_run == !$past(wr_data[7])));

endmodule

// File: tb/sim_rtcf_regfile.sv
module sim_rtcf_regfile;
  localparam int AW  = 19;
  localparam int DLY = 50;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en;
  logic          cs_n, oe_n, we_n;
  logic          ram_sel;
  logic [63:0]   cnt_bus;
  logic          tick_1s, tick_512, batt_ok;
  logic          osc_run, load_en;
  logic [63:0]   load_bus;
  logic [7:0]    cnt [8];

  int checks = 0;
  int fails  = 0;
  int ld_cnt = 0;
  logic [63:0] ld_val = '0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) cnt_bus[i*8 +: 8] = cnt[i];

  rtcf_regfile #(.AW(AW), .REFRESH_DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .ram_sel(ram_sel), .cnt_bus(cnt_bus), .tick_1s(tick_1s),
    .tick_512(tick_512), .batt_ok(batt_ok), .osc_run(osc_run),
    .load_en(load_en), .load_bus(load_bus)
  );

  always @(posedge clk) begin
    if (rst_n && load_en) begin
      ld_cnt = ld_cnt + 1;
      ld_val = load_bus;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ta(input logic [2:0] idx);
    return {{(AW-3){1'b1}}, idx};
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    addr = ta(idx); din = d; cs_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    cs_n = 1; we_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] v);
    @(negedge clk);
    addr = ta(idx); cs_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    v = dout;
    chk("R2 read enable", {7'd0, dout_en}, 8'h01);
    cs_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_1s();
    @(negedge clk); tick_1s = 1;
    @(negedge clk); tick_1s = 0;
  endtask

  task automatic pulse_512();
    @(negedge clk); tick_512 = 1;
    @(negedge clk); tick_512 = 0;
  endtask

  task automatic t_reset();
    chk("R13 dout_en in reset", {7'd0, dout_en}, 8'h00);
    chk("R13 load_en in reset", {7'd0, load_en}, 8'h00);
    chk("R13 osc_run in reset", {7'd0, osc_run}, 8'h01);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rd_chk("R13 control bits clear", 3'd0, 8'h20);
    rd_chk("R12 battery flag after reset", 3'd4, 8'h83);
  endtask

  task automatic t_transparent();
    rd_chk("R1 year register", 3'd7, 8'h24);
    rd_chk("R1 month register", 3'd6, 8'h06);
    cnt[1] = 8'h46;
    @(negedge clk);
    rd_chk("R3 follows counter", 3'd1, 8'h46);
  endtask

  task automatic t_bus();
    @(negedge clk);
    addr = 19'h00010; cs_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk("R1 ram_sel low address", {7'd0, ram_sel}, 8'h01);
    chk("R1 no drive low address", {7'd0, dout_en}, 8'h00);
    cs_n = 1; oe_n = 1;
    @(negedge clk);
    addr = ta(3'd2); din = 8'h55; cs_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk);
    chk("R2 no drive while writing", {7'd0, dout_en}, 8'h00);
    chk("R1 ram_sel clear at top", {7'd0, ram_sel}, 8'h00);
    cs_n = 1; we_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    chk("R2 idle no drive", {7'd0, dout_en}, 8'h00);
    rd_chk("R8 minutes ignore write", 3'd2, 8'h30);
    wr(3'd7, 8'h99);
    rd_chk("R8 year ignore write", 3'd7, 8'h24);
  endtask

  task automatic t_freeze();
    wr(3'd0, 8'h40);
    rd_chk("R4 freeze bit reads back", 3'd0, 8'h60);
    cnt[1] = 8'h50; cnt[2] = 8'h31;
    repeat (2) @(negedge clk);
    rd_chk("R4 seconds frozen", 3'd1, 8'h46);
    rd_chk("R4 minutes frozen", 3'd2, 8'h30);
  endtask

  task automatic t_release();
    wr(3'd0, 8'h00);
    rd_chk("R5 held until refresh", 3'd1, 8'h46);
    rd_chk("R8 century kept", 3'd0, 8'h20);
    pulse_1s();
    rd_chk("R5 refresh on tick sec", 3'd1, 8'h50);
    rd_chk("R5 refresh on tick min", 3'd2, 8'h31);
    wr(3'd0, 8'h40);
    cnt[1] = 8'h51;
    wr(3'd0, 8'h00);
    repeat (DLY - 15) @(negedge clk);
    rd_chk("R5 before delay expires", 3'd1, 8'h50);
    repeat (20) @(negedge clk);
    rd_chk("R5 refresh after delay", 3'd1, 8'h51);
  endtask

  task automatic t_hold();
    wr(3'd0, 8'hA1);
    cnt[3] = 8'h13;
    rd_chk("R6 hold bit reads back", 3'd0, 8'hA1);
    wr(3'd6, 8'hD2);
    rd_chk("R9 month masked", 3'd6, 8'h12);
    wr(3'd3, 8'h08);
    rd_chk("R6 hour written", 3'd3, 8'h08);
    wr(3'd1, 8'h07);
    rd_chk("R6 seconds written", 3'd1, 8'h07);
    rd_chk("R6 minutes held", 3'd2, 8'h31);
    chk("R7 no load during hold", 8'(ld_cnt), 8'h00);
  endtask

  task automatic t_load();
    wr(3'd0, 8'h21);
    repeat (2) @(negedge clk);
    chk("R7 one load pulse", 8'(ld_cnt), 8'h01);
    chk("R7 load month", ld_val[55:48], 8'h12);
    chk("R7 load hour", ld_val[31:24], 8'h08);
    chk("R7 load seconds", ld_val[15:8], 8'h07);
    chk("R7 load century", ld_val[7:0], 8'h21);
    for (int i = 0; i < 8; i++) cnt[i] = ld_val[i*8 +: 8];
    pulse_1s();
    rd_chk("R7 hour after load", 3'd3, 8'h08);
    rd_chk("R7 month after load", 3'd6, 8'h12);
    chk("R7 still one load pulse", 8'(ld_cnt), 8'h01);
  endtask

  task automatic t_osc();
    wr(3'd1, 8'h80);
    chk("R10 osc stopped", {7'd0, osc_run}, 8'h00);
    rd_chk("R10 stop bit reads back", 3'd1, 8'h87);
    @(negedge clk);
    addr = ta(3'd1); din = 8'h00; cs_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    cs_n = 1;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    chk("R2 chip-enable ended write", {7'd0, osc_run}, 8'h01);
  endtask

  task automatic t_ftest();
    wr(3'd4, 8'h40);
    rd_chk("R11 test bit reads back", 3'd4, 8'hC3);
    rd_chk("R11 phase starts low", 3'd1, 8'h06);
    pulse_512();
    rd_chk("R11 phase toggled high", 3'd1, 8'h07);
    pulse_512();
    rd_chk("R11 phase toggled low", 3'd1, 8'h06);
    pulse_512();
    wr(3'd1, 8'h80);
    rd_chk("R11 osc stop gates phase", 3'd1, 8'h87);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00);
    rd_chk("R11 test bit cleared", 3'd4, 8'h83);
  endtask

  task automatic t_batt();
    batt_ok = 0;
    rd_chk("R12 exhausted flag", 3'd4, 8'h03);
    wr(3'd4, 8'h80);
    rd_chk("R12 flag not writable", 3'd4, 8'h03);
    batt_ok = 1;
    rd_chk("R12 good flag", 3'd4, 8'h83);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; din = '0; cs_n = 1; oe_n = 1; we_n = 1;
    tick_1s = 0; tick_512 = 0; batt_ok = 1;
    cnt[0] = 8'h20; cnt[1] = 8'h45; cnt[2] = 8'h30; cnt[3] = 8'h12;
    cnt[4] = 8'h03; cnt[5] = 8'h15; cnt[6] = 8'h06; cnt[7] = 8'h24;
    repeat (3) @(negedge clk);
    t_reset();
    t_transparent();
    t_bus();
    t_freeze();
    t_release();
    t_hold();
    t_load();
    t_osc();
    t_ftest();
    t_batt();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule